// File: doc/BRIEF.md
# Byte Memory Strobe Mode Decoder

This block models the control front end of a small byte-wide programmable memory. From the active-low chip-enable and output-enable strobes, a flag that says the programming supply is high, and a flag that says one address line carries the identify voltage, it picks one of seven operating modes. The mode then selects what the block places on the data outputs: a byte from the internal array, one of two fixed identifier bytes chosen by address bit 0, or nothing at all.

In program mode the block accepts the input byte for the addressed location. Programming can only move bits from one to zero. A separate erase input returns every location to FFh, and it works only while the programming supply flag is high. With the supply flag low, the array can be read but cannot be changed. Analog levels and timing are not modelled: every input is a clocked logic-level flag, the mode and outputs follow the inputs combinationally, and array updates take effect at the rising clock edge.

Top module: `mem_mode_dec`

## Requirements
- R1: With ce_n=0, oe_n=0 and id_hv=0, the mode is 0 (array read) at either supply level, dout_en=1 and dout equals the addressed array byte.
- R2: With vpp_hi=0, ce_n=0 and oe_n=1, the mode is 1 (output off) and dout_en=0.
- R3: With vpp_hi=0 and ce_n=1, the mode is 2 (standby) and dout_en=0, whatever oe_n is.
- R4: With ce_n=0, oe_n=0 and id_hv=1, the mode is 3 (identify) and dout is C2h when addr[0]=0 and C0h when addr[0]=1.
- R5: With vpp_hi=1, ce_n=0 and oe_n=1, the mode is 4 (program), dout_en=0, and at the next rising edge the addressed byte becomes its old value AND din.
- R6: With vpp_hi=1, ce_n=1 and oe_n=0, the mode is 5 (verify), dout_en=1 and dout equals the addressed array byte.
- R7: With vpp_hi=1, ce_n=1 and oe_n=1, the mode is 6 (inhibit), dout_en=0 and no location changes.
- R8: While vpp_hi=0, no array byte changes, whatever erase, din or the strobes do.
- R9: erase=1 with vpp_hi=1 sets every location to FFh at the next rising edge. In the same cycle it takes priority over a program operation.
- R10: After reset every location holds FFh.
- R11: Whenever dout_en=0, dout is 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| vpp_hi | input | 1 | Programming supply is high |
| id_hv | input | 1 | Identify voltage present on the address line |
| erase | input | 1 | Whole-array erase request |
| addr | input | AW | Byte address |
| din | input | 8 | Program data |
| dout | output | 8 | Read data, 00h when not driving |
| dout_en | output | 1 | Output driver enable; low means high impedance |
| mode | output | 3 | Decoded mode code |

## Verification
Two of the block's functions can be requested in the same cycle: an erase and a byte program. This happens when erase is held high while the strobes select program mode with the supply flag set. The bench forces this case directly on an address whose stored value is known. It then reads that location and a second one in verify mode, and both must return FFh. The random stimulus also sets erase now and then during program cycles, and the reference model applies the same rule that erase takes priority.

// File: rtl/memdec_pkg.sv
package memdec_pkg;
  typedef enum logic [2:0] {
    MD_READ  = 3'd0,
    MD_OFF   = 3'd1,
    MD_IDLE  = 3'd2,
    MD_IDENT = 3'd3,
    MD_PROG  = 3'd4,
    MD_VFY   = 3'd5,
    MD_HOLD  = 3'd6
  } mode_e;
endpackage

// File: rtl/memdec_mode.sv
module memdec_mode
  import memdec_pkg::*;
(
  input  logic  ce_n,
  input  logic  oe_n,
  input  logic  vpp_hi,
  input  logic  id_hv,
  output mode_e mode
);
  always_comb begin
    if (ce_n) begin
      if (vpp_hi) mode = oe_n ? MD_HOLD : MD_VFY;
      else        mode = MD_IDLE;
    end else if (oe_n) begin
      mode = vpp_hi ? MD_PROG : MD_OFF;
    end else begin
      mode = id_hv ? MD_IDENT : MD_READ;
    end
  end
endmodule

// File: rtl/memdec_array.sv
module memdec_array #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          ers_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data
);
  localparam logic [DW-1:0] ERASED = {DW{1'b1}};

  logic [DW-1:0] word_q [DEPTH];
  logic [DW-1:0] word_d [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    logic hit;
    assign hit = wr_en && (addr == AW'(i));

    always_comb begin
      word_d[i] = word_q[i];
      if (ers_en)   word_d[i] = ERASED;
      else if (hit) word_d[i] = word_q[i] & wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                word_q[i] <= ERASED;
      else if (ers_en || hit)    word_q[i] <= word_d[i];
    end

    // R9
    erase_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ers_en |=> word_q[i] == ERASED);
    // R5
    prog_clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !ers_en) |=> ((word_q[i] & ~$past(word_q[i])) == '0));
    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en || ers_en) |=> $stable(word_q[i]));
  end

  assign rd_data = word_q[addr];
endmodule

// File: rtl/memdec_outsel.sv
module memdec_outsel
  import memdec_pkg::*;
#(
  parameter int          DW       = 8,
  parameter logic [DW-1:0] MFR_CODE = 8'hC2,
  parameter logic [DW-1:0] DEV_CODE = 8'hC0
) (
  input  mode_e         mode,
  input  logic          sel0,
  input  logic [DW-1:0] arr_data,
  output logic [DW-1:0] dout,
  output logic          dout_en
);
  always_comb begin
    dout    = '0;
    dout_en = 1'b0;
    unique case (mode)
      MD_READ, MD_VFY: begin
        dout_en = 1'b1;
        dout    = arr_data;
      end
      MD_IDENT: begin
        dout_en = 1'b1;
        dout    = sel0 ? DEV_CODE : MFR_CODE;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/mem_mode_dec.sv
module mem_mode_dec
  import memdec_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          vpp_hi,
  input  logic          id_hv,
  input  logic          erase,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    din,
  output logic [7:0]    dout,
  output logic          dout_en,
  output logic [2:0]    mode
);
  localparam int DW = 8;

  logic [1:0]    rst_sync_q;
  logic          rst_int_n;
  mode_e         mode_w;
  logic          wr_en;
  logic          ers_en;
  logic [DW-1:0] rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  memdec_mode u_mode (
    .ce_n   (ce_n),
    .oe_n   (oe_n),
    .vpp_hi (vpp_hi),
    .id_hv  (id_hv),
    .mode   (mode_w)
  );

  assign wr_en  = (mode_w == MD_PROG);
  assign ers_en = erase && vpp_hi;

  memdec_array #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_array (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (wr_en),
    .ers_en  (ers_en),
    .addr    (addr),
    .wr_data (din),
    .rd_data (rd_data)
  );

  memdec_outsel #(.DW(DW)) u_out (
    .mode     (mode_w),
    .sel0     (addr[0]),
    .arr_data (rd_data),
    .dout     (dout),
    .dout_en  (dout_en)
  );

  assign mode = mode_w;

  // R11
  quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !dout_en |-> dout == 8'h00);
  // R3
  standby_hiz_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ce_n && !vpp_hi) |-> !dout_en);
  // R4
  ident_code_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!ce_n && !oe_n && id_hv) |-> dout == (addr[0] ? 8'hC0 : 8'hC2));
  // R8
  vpp_lock_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !vpp_hi |=> (addr != $past(addr) || rd_data == $past(rd_data)));
endmodule

// File: tb/sim_mem_mode_dec.sv
module sim_mem_mode_dec;
  localparam int DEPTH = 16;
  localparam int AW    = 4;

  logic          clk = 1'b0;
  logic          rst_n, ce_n, oe_n, vpp_hi, id_hv, erase;
  logic [AW-1:0] addr;
  logic [7:0]    din, dout;
  logic          dout_en;
  logic [2:0]    mode;

  int checks = 0, failures = 0;
  bit finished = 0;
  logic [7:0] ref_mem [DEPTH];

  always #10 clk = ~clk;

  mem_mode_dec #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .vpp_hi(vpp_hi),
    .id_hv(id_hv), .erase(erase), .addr(addr), .din(din),
    .dout(dout), .dout_en(dout_en), .mode(mode)
  );

  function automatic logic [2:0] exp_mode(logic c, logic o, logic v, logic i);
    if (c)      return v ? (o ? 3'd6 : 3'd5) : 3'd2;
    else if (o) return v ? 3'd4 : 3'd1;
    else        return i ? 3'd3 : 3'd0;
  endfunction

  function automatic string req_of(logic [2:0] m);
    case (m)
      3'd0: return "R1";  3'd1: return "R2";  3'd2: return "R3";
      3'd3: return "R4";  3'd4: return "R5";  3'd5: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(string req, logic [8:0] act, logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, check combinational outputs, then apply the edge
  task automatic step(logic c, logic o, logic v, logic i, logic e,
                      logic [AW-1:0] a, logic [7:0] d, string tag = "");
    logic [2:0] em;
    logic [7:0] ed;
    logic       een;
    @(negedge clk);
    ce_n = c; oe_n = o; vpp_hi = v; id_hv = i; erase = e; addr = a; din = d;
    #2;
    em  = exp_mode(c, o, v, i);
    een = (em == 3'd0 || em == 3'd3 || em == 3'd5);
    ed  = (em == 3'd3) ? (a[0] ? 8'hC0 : 8'hC2) : (een ? ref_mem[a] : 8'h00);
    check({req_of(em), " ", tag, " mode"}, {6'd0, mode}, {6'd0, em});
    check({een ? req_of(em) : "R11", " ", tag, " bus"}, {dout_en, dout}, {een, ed});
    @(posedge clk);
    if (v && e) for (int k = 0; k < DEPTH; k++) ref_mem[k] = 8'hFF;
    else if (em == 3'd4) ref_mem[a] = ref_mem[a] & d;
  endtask

  initial begin
    for (int n = 0; n < 20000; n++) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 0; ce_n = 1; oe_n = 1; vpp_hi = 0; id_hv = 0; erase = 0;
    addr = '0; din = '0;
    for (int k = 0; k < DEPTH; k++) ref_mem[k] = 8'hFF;
    repeat (3) @(posedge clk);
    rst_n = 1;
    repeat (3) @(posedge clk);

    // R10 reset contents
    for (int k = 0; k < DEPTH; k++) step(0, 0, 0, 0, 0, AW'(k), 8'h00, "R10");

    // R4 identifier codes
    step(0, 0, 0, 1, 0, 4'd0, 8'h00, "R4 mfr");
    step(0, 0, 0, 1, 0, 4'd1, 8'h00, "R4 dev");
    step(0, 0, 1, 1, 0, 4'd3, 8'h00, "R4 dev vpp");

    // R5 programming clears bits only
    step(0, 1, 1, 0, 0, 4'd5, 8'hA5, "R5 prog");
    step(0, 1, 1, 0, 0, 4'd5, 8'h3C, "R5 prog and");
    step(1, 0, 1, 0, 0, 4'd5, 8'h00, "R6 verify");

    // R8 low supply: program strobes and erase have no effect
    step(0, 1, 0, 0, 1, 4'd5, 8'h00, "R8 lock");
    step(1, 1, 0, 0, 1, 4'd5, 8'h00, "R8 lock");
    step(0, 0, 0, 0, 0, 4'd5, 8'h00, "R8 readback");

    // R7 inhibit writes nothing
    step(1, 1, 1, 0, 0, 4'd5, 8'h00, "R7 inhibit");
    step(1, 0, 1, 0, 0, 4'd5, 8'h00, "R7 readback");

    // R9 erase and program in the same cycle: erase wins
    step(0, 1, 1, 0, 0, 4'd9, 8'h0F, "R9 setup");
    step(0, 1, 1, 0, 1, 4'd9, 8'h00, "R9 collide");
    step(1, 0, 1, 0, 0, 4'd9, 8'h00, "R9 readback");
    step(1, 0, 1, 0, 0, 4'd5, 8'h00, "R9 other");

    // R3 standby ignores oe
    step(1, 0, 0, 0, 0, 4'd2, 8'h00, "R3 oe low");
    step(1, 1, 0, 1, 0, 4'd2, 8'h00, "R3 oe high");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [3:0] r;
      r = 4'($urandom);
      step(1'($urandom), 1'($urandom), 1'($urandom), ($urandom % 4) == 0,
           ($urandom % 32) == 0, AW'($urandom), 8'($urandom), "rand");
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule